// File: doc/BRIEF.md
# Predicated Contiguous Vector Load Sequencer

This block executes one masked load of a contiguous run of doublewords into a vector register. A single `start` pulse captures a base address, a scalar index, a byte-granular predicate and an element-width select. The block forms the first address by scaling the index to bytes and adding it to the base. It then walks the element slots from lane 0 upward and issues one 64-bit read for each active slot on a request/response memory port. Inactive slots are skipped without touching memory. When the last slot is finished, the assembled vector is written out in one beat, together with a one-cycle `done`.

Two element widths are supported. In narrow mode each lane is 64 bits wide. In wide mode each lane is 128 bits wide, and the doubleword read for it is zero-extended into the lane. The base comes either from a general register or, when the base selector is 31, from the stack pointer. A stack-pointer base must be 16-byte aligned. If it is not, the block reports a fault, makes no reads and skips the vector write. A configuration input decides whether that check still applies when no element is active.

The controller is a state machine with these states:
- `ST_IDLE` waits for `start`.
- `ST_CHECK` evaluates the alignment rule.
- `ST_PICK` tests the current slot and either skips it or goes to issue a read.
- `ST_ISSUE` holds the request until it is accepted.
- `ST_WAIT` waits for the response.
- `ST_DONE` writes the vector.
- `ST_FAULT` reports the fault.

Its transitions are:
- IDLE→CHECK on `start`.
- CHECK→FAULT when the alignment rule fails, otherwise CHECK→PICK.
- PICK→ISSUE for an active slot.
- PICK→PICK to skip an inactive slot that is not the last one.
- PICK→DONE when an inactive slot is the last one.
- ISSUE→WAIT on `mem_req_ready`.
- WAIT→PICK, or WAIT→DONE for the last slot, on `mem_rsp_valid`.
- DONE→IDLE and FAULT→IDLE unconditionally.

Top module: `vload_seq`

## Requirements
- R1: The first read address is the selected base plus the index shifted left by 3, computed modulo 2^64.
- R2: Every element slot moves the address on by 8 bytes, whether or not the slot is active. Reads are issued in ascending lane order, and all arithmetic wraps modulo 2^64.
- R3: An inactive slot issues no read, and its lane in the written vector is all zeros.
- R4: In narrow mode (`wide_elem`=0) there are VLEN/64 lanes. Lane e occupies bits [64e+63:64e] and is active when `pred[8e]` is 1.
- R5: In wide mode (`wide_elem`=1) there are VLEN/128 lanes. Lane e is active when `pred[16e]` is 1. Its loaded doubleword lands in bits [128e+63:128e], and bits [128e+127:128e+64] are zero.
- R6: When `base_sel` equals 31 the base is `sp_val`, otherwise it is `base_gpr`. A misaligned general-register base never faults.
- R7: A stack-pointer base whose low 4 bits are not all zero, with at least one active lane, ends the operation with `done` and `fault` high, `vec_we` low and no memory read.
- R8: A misaligned stack-pointer base with no active lane faults when `sp_chk_idle` is 1. When `sp_chk_idle` is 0 it completes normally and writes an all-zero vector.
- R9: `done` is a one-cycle pulse. On success `vec_we` is high in the same single cycle and `vec_wdata` carries the complete vector.
- R10: `mem_req_valid` stays high with a stable address until `mem_req_ready`, and at most one read is outstanding.
- R11: Reset, including a reset in the middle of an operation, returns the block to idle with `done`, `fault`, `vec_we` and `mem_req_valid` low and no further reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation; ignored unless idle |
| base_sel | input | 5 | Base register selector; 31 selects the stack pointer |
| base_gpr | input | 64 | General-register base value |
| sp_val | input | 64 | Stack-pointer value |
| index_val | input | 64 | Scalar element index; never modified |
| pred | input | VLEN/8 | Predicate, one bit per vector byte |
| wide_elem | input | 1 | 0: 64-bit lanes, 1: 128-bit lanes |
| sp_chk_idle | input | 1 | Apply the stack-pointer alignment check when no lane is active |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 64 | Read byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data |
| done | output | 1 | Operation finished (pulse) |
| fault | output | 1 | Alignment fault, valid with `done` |
| vec_we | output | 1 | Destination vector write strobe |
| vec_wdata | output | VLEN | Assembled destination vector |

## Verification
The hardest case to reach is a predicate that is active only in bytes that are not the lowest byte of a wide lane. For example, byte 8 alone is set in wide mode. No lane is then active, although the same predicate would activate lane 1 in narrow mode. Combined with a misaligned stack pointer and the idle-check bit cleared, this must complete without a fault. The stimulus table pairs such predicates with both widths and both settings of the configuration bit. A memory model that withholds `mem_req_ready` on some cycles makes held requests occur, and an asynchronous reset is applied while a request is outstanding.

// File: rtl/vls_pkg.sv
`timescale 1ns/1ps
package vls_pkg;
    localparam int unsigned ADDR_W     = 64;
    localparam int unsigned BEAT_W     = 64;
    localparam int unsigned BEAT_BYTES = BEAT_W / 8;
    localparam int unsigned IDX_SHIFT  = 3;
    localparam logic [4:0]  SP_SEL     = 5'd31;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_PICK,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE,
        ST_FAULT
    } vls_state_e;
endpackage

// File: rtl/vls_addr_gen.sv
`timescale 1ns/1ps
module vls_addr_gen
    import vls_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] index,
    input  logic              step,
    output logic [ADDR_W-1:0] addr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= base + (index << IDX_SHIFT);
        end else if (step) begin
            addr <= addr + ADDR_W'(BEAT_BYTES);
        end
    end

    assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (addr == $past(addr) + ADDR_W'(BEAT_BYTES)));
endmodule

// File: rtl/vls_lane_active.sv
`timescale 1ns/1ps
module vls_lane_active #(
    parameter int unsigned VLEN = 256
) (
    input  logic [VLEN/8-1:0]              pred,
    input  logic                           wide,
    input  logic [$clog2(VLEN/64)-1:0]     lane,
    output logic                           active,
    output logic                           any_active,
    output logic                           is_last
);
    localparam int unsigned NE_NARROW = VLEN / 64;
    localparam int unsigned NE_WIDE   = VLEN / 128;
    localparam int unsigned LANE_W    = $clog2(NE_NARROW);

    logic [NE_NARROW-1:0] act_n;
    logic [NE_NARROW-1:0] act_w;

    for (genvar e = 0; e < NE_NARROW; e++) begin : g_lane
        assign act_n[e] = pred[e*8];
        if (e < NE_WIDE) begin : g_wide
            assign act_w[e] = pred[e*16];
        end else begin : g_pad
            assign act_w[e] = 1'b0;
        end
    end

    always_comb begin
        active     = wide ? act_w[lane] : act_n[lane];
        any_active = wide ? (|act_w) : (|act_n);
        is_last    = wide ? (lane == LANE_W'(NE_WIDE - 1))
                          : (lane == LANE_W'(NE_NARROW - 1));
    end
endmodule

// File: rtl/vls_assemble.sv
`timescale 1ns/1ps
module vls_assemble
    import vls_pkg::*;
#(
    parameter int unsigned VLEN = 256
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr,
    input  logic                        wr,
    input  logic                        wide,
    input  logic [$clog2(VLEN/64)-1:0]  lane,
    input  logic [BEAT_W-1:0]           data,
    output logic [VLEN-1:0]             result
);
    localparam int unsigned OFF_W = $clog2(VLEN);

    logic [OFF_W:0] off;

    always_comb begin
        off = wide ? ((OFF_W+1)'(lane) << 7) : ((OFF_W+1)'(lane) << 6);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result <= '0;
        end else if (clr) begin
            result <= '0;
        end else if (wr) begin
            result[off[OFF_W-1:0] +: BEAT_W] <= data;
        end
    end

    assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (result == '0));
endmodule

// File: rtl/vload_seq.sv
`timescale 1ns/1ps
module vload_seq
    import vls_pkg::*;
#(
    parameter int unsigned VLEN = 256
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [4:0]          base_sel,
    input  logic [63:0]         base_gpr,
    input  logic [63:0]         sp_val,
    input  logic [63:0]         index_val,
    input  logic [VLEN/8-1:0]   pred,
    input  logic                wide_elem,
    input  logic                sp_chk_idle,
    output logic                mem_req_valid,
    input  logic                mem_req_ready,
    output logic [63:0]         mem_req_addr,
    input  logic                mem_rsp_valid,
    input  logic [63:0]         mem_rsp_data,
    output logic                done,
    output logic                fault,
    output logic                vec_we,
    output logic [VLEN-1:0]     vec_wdata
);
    localparam int unsigned NE_NARROW = VLEN / 64;
    localparam int unsigned LANE_W    = $clog2(NE_NARROW);
    localparam int unsigned PRED_W    = VLEN / 8;

    vls_state_e            state, state_nx;
    logic [LANE_W-1:0]     lane;
    logic [PRED_W-1:0]     pred_q;
    logic                  wide_q, sp_q, mis_q, cfg_q;
    logic                  lane_act, any_act, lane_last;
    logic                  load, slot_done, bad_sp;
    logic [ADDR_W-1:0]     sel_base;

    assign load      = (state == ST_IDLE) && start;
    assign slot_done = ((state == ST_PICK) && !lane_act) ||
                       ((state == ST_WAIT) && mem_rsp_valid);
    assign sel_base  = (base_sel == SP_SEL) ? sp_val : base_gpr;
    assign bad_sp    = sp_q && mis_q && (any_act || cfg_q);

    vls_lane_active #(.VLEN(VLEN)) u_lane (
        .pred       (pred_q),
        .wide       (wide_q),
        .lane       (lane),
        .active     (lane_act),
        .any_active (any_act),
        .is_last    (lane_last)
    );

    vls_addr_gen u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .base  (sel_base),
        .index (index_val),
        .step  (slot_done),
        .addr  (mem_req_addr)
    );

    vls_assemble #(.VLEN(VLEN)) u_asm (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (load),
        .wr     ((state == ST_WAIT) && mem_rsp_valid),
        .wide   (wide_q),
        .lane   (lane),
        .data   (mem_rsp_data),
        .result (vec_wdata)
    );

    // State register and per-operation context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            lane   <= '0;
            pred_q <= '0;
            wide_q <= 1'b0;
            sp_q   <= 1'b0;
            mis_q  <= 1'b0;
            cfg_q  <= 1'b0;
        end else begin
            state <= state_nx;
            if (load) begin
                lane   <= '0;
                pred_q <= pred;
                wide_q <= wide_elem;
                sp_q   <= (base_sel == SP_SEL);
                mis_q  <= (sp_val[3:0] != 4'd0);
                cfg_q  <= sp_chk_idle;
            end else if (slot_done && !lane_last) begin
                lane <= lane + LANE_W'(1);
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_CHECK;
            ST_CHECK: state_nx = bad_sp ? ST_FAULT : ST_PICK;
            ST_PICK: begin
                if (lane_act)       state_nx = ST_ISSUE;
                else if (lane_last) state_nx = ST_DONE;
            end
            ST_ISSUE: if (mem_req_ready) state_nx = ST_WAIT;
            ST_WAIT:  if (mem_rsp_valid) state_nx = lane_last ? ST_DONE : ST_PICK;
            ST_DONE:  state_nx = ST_IDLE;
            ST_FAULT: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        mem_req_valid = 1'b0;
        done          = 1'b0;
        fault         = 1'b0;
        vec_we        = 1'b0;
        unique case (state)
            ST_ISSUE: mem_req_valid = 1'b1;
            ST_DONE: begin
                done   = 1'b1;
                vec_we = 1'b1;
            end
            ST_FAULT: begin
                done  = 1'b1;
                fault = 1'b1;
            end
            default: ;
        endcase
    end

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    assert_one_outstanding_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_fault_no_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> ($past(state) == ST_CHECK));
endmodule

// File: tb/test_vload_seq.sv
`timescale 1ns/1ps
module test_vload_seq;
    localparam int unsigned VLEN = 256;
    localparam int unsigned PW   = VLEN / 8;

    typedef struct packed {
        logic [4:0]    sel;
        logic [63:0]   base;
        logic [63:0]   sp;
        logic [63:0]   idx;
        logic [PW-1:0] pred;
        logic          wide;
        logic          cfg;
        logic          xfault;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{5'd2,  64'h1000,                64'h0,    64'h2,                  32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0},
        '{5'd3,  64'h4000,                64'h0,    64'h10,                 32'h0000_0101, 1'b0, 1'b0, 1'b0},
        '{5'd4,  64'h8000_0000,           64'h0,    64'h1,                  32'h0100_0000, 1'b0, 1'b0, 1'b0},
        '{5'd7,  64'h2_0000,              64'h0,    64'h3,                  32'h0001_0001, 1'b1, 1'b0, 1'b0},
        '{5'd7,  64'h2_0000,              64'h0,    64'h3,                  32'h0000_0100, 1'b1, 1'b0, 1'b0},
        '{5'd31, 64'hDEAD_0000,           64'h3000, 64'h4,                  32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0},
        '{5'd31, 64'h1000,                64'h3008, 64'h0,                  32'h0000_0001, 1'b0, 1'b0, 1'b1},
        '{5'd31, 64'h1000,                64'h3004, 64'h0,                  32'h0000_0000, 1'b0, 1'b1, 1'b1},
        '{5'd31, 64'h1000,                64'h3004, 64'h0,                  32'h0000_0000, 1'b0, 1'b0, 1'b0},
        '{5'd1,  64'hFFFF_FFFF_FFFF_FFF0, 64'h0,    64'h0,                  32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0},
        '{5'd5,  64'h1003,                64'h0,    64'h1,                  32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0},
        '{5'd0,  64'h100,                 64'h0,    64'h2000_0000_0000_0001, 32'h0101_0000, 1'b0, 1'b0, 1'b0},
        '{5'd31, 64'h1000,                64'h300C, 64'h0,                  32'h0000_0100, 1'b1, 1'b0, 1'b0}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [4:0]      base_sel = '0;
    logic [63:0]     base_gpr = '0, sp_val = '0, index_val = '0;
    logic [PW-1:0]   pred = '0;
    logic            wide_elem = 1'b0, sp_chk_idle = 1'b0;
    logic            mem_req_valid, mem_req_ready;
    logic [63:0]     mem_req_addr;
    logic            mem_rsp_valid;
    logic [63:0]     mem_rsp_data;
    logic            done, fault, vec_we;
    logic [VLEN-1:0] vec_wdata;

    int n_chk = 0;
    int n_fail = 0;
    int n_rd = 0;
    logic [63:0] rd_log [0:1023];
    logic [1:0]  rdy_cnt;

    always #4 clk = ~clk;

    vload_seq #(.VLEN(VLEN)) i_vload_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .base_sel(base_sel),
        .base_gpr(base_gpr), .sp_val(sp_val), .index_val(index_val),
        .pred(pred), .wide_elem(wide_elem), .sp_chk_idle(sp_chk_idle),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .done(done), .fault(fault),
        .vec_we(vec_we), .vec_wdata(vec_wdata)
    );

    function automatic logic [63:0] memval(logic [63:0] a);
        return {a[31:0], a[63:32]} ^ 64'h5A5A_C3C3_0F0F_9669;
    endfunction

    // Memory model: accepts on three cycles out of four, answers one cycle later
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdy_cnt       <= 2'd0;
            mem_req_ready <= 1'b0;
            mem_rsp_valid <= 1'b0;
            mem_rsp_data  <= '0;
        end else begin
            rdy_cnt       <= rdy_cnt + 2'd1;
            mem_req_ready <= (rdy_cnt != 2'd2);
            mem_rsp_valid <= mem_req_valid && mem_req_ready;
            mem_rsp_data  <= memval(mem_req_addr);
            if (mem_req_valid && mem_req_ready) begin
                rd_log[n_rd % 1024] <= mem_req_addr;
                n_rd <= n_rd + 1;
            end
        end
    end

    task automatic chk(string req, int id, logic [VLEN-1:0] got, logic [VLEN-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s case %0d: actual %h expected %h", req, id, got, exp);
        end
    endtask

    task automatic run_vec(vec_t v, int id);
        logic [63:0]     eb, a0;
        logic [VLEN-1:0] exp_data;
        logic [63:0]     exp_addr [0:3];
        int              nexp, nlanes, n0, k;
        logic            act, seen, xf;
        exp_data = '0;
        nexp     = 0;
        eb       = (v.sel == 5'd31) ? v.sp : v.base;          // R6
        a0       = eb + (v.idx << 3);                           // R1
        nlanes   = v.wide ? VLEN/128 : VLEN/64;
        xf       = v.xfault;
        for (int e = 0; e < nlanes; e++) begin
            act = v.wide ? v.pred[e*16] : v.pred[e*8];          // R4 R5
            if (act && !xf) begin
                exp_addr[nexp] = a0 + 64'(8*e);                 // R2
                nexp++;
                if (v.wide) exp_data[e*128 +: 64] = memval(a0 + 64'(8*e));
                else        exp_data[e*64  +: 64] = memval(a0 + 64'(8*e));
            end
        end
        @(negedge clk);
        base_sel = v.sel; base_gpr = v.base; sp_val = v.sp; index_val = v.idx;
        pred = v.pred; wide_elem = v.wide; sp_chk_idle = v.cfg;
        n0 = n_rd;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        seen = 1'b0;
        for (int c = 0; c < 300; c++) begin
            if (done) begin
                seen = 1'b1;
                break;
            end
            @(negedge clk);
        end
        chk("R9 done seen", id, VLEN'(seen), VLEN'(1));
        if (seen) begin
            chk("R7 R8 fault", id, VLEN'(fault), VLEN'(xf));
            chk("R9 vec_we", id, VLEN'(vec_we), VLEN'(!xf));
            if (!xf) chk("R3 R4 R5 vector", id, vec_wdata, exp_data);
            chk("R3 R7 read count", id, VLEN'(n_rd - n0), VLEN'(nexp));
            k = 0;
            while (k < nexp && (n0 + k) < n_rd) begin
                chk("R1 R2 R6 address", id, VLEN'(rd_log[(n0 + k) % 1024]), VLEN'(exp_addr[k]));
                k++;
            end
            @(negedge clk);
            chk("R9 done pulse", id, VLEN'(done), VLEN'(0));
        end
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int n0;
        logic hit;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 reset idle", -1, VLEN'({done, fault, vec_we, mem_req_valid}), VLEN'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 after release", -1, VLEN'({done, fault, vec_we, mem_req_valid}), VLEN'(0));

        for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

        // R11: reset while a request is pending
        @(negedge clk);
        base_sel = 5'd2; base_gpr = 64'h5000; index_val = 64'h0;
        pred = '1; wide_elem = 1'b0; sp_chk_idle = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        hit = 1'b0;
        for (int c = 0; c < 20; c++) begin
            if (mem_req_valid) begin
                hit = 1'b1;
                break;
            end
            @(negedge clk);
        end
        chk("R11 request reached", 100, VLEN'(hit), VLEN'(1));
        rst_n = 1'b0;
        #1;
        chk("R11 mid-run reset", 100, VLEN'({done, fault, vec_we, mem_req_valid}), VLEN'(0));
        @(negedge clk);
        rst_n = 1'b1;
        n0 = n_rd;
        repeat (10) @(negedge clk);
        chk("R11 no reads after reset", 100, VLEN'(n_rd - n0), VLEN'(0));
        chk("R11 no done after reset", 100, VLEN'(done), VLEN'(0));

        // A full operation still works after the aborted one
        run_vec(VECS[1], 101);
        run_vec(VECS[3], 102);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule